// File: doc/BRIEF.md
# Programmable Raster Video Timing Generator

This block produces the line and frame timing for a raster display: horizontal sync, vertical sync, data enable and a polarity-adjusted pixel data bus, one pixel per clock. Each line runs through four regions in a fixed order: sync, back porch, active and front porch. The frame does the same in lines. Every region length is programmed as its count minus one, so a field of zero gives a one-pixel or one-line region.

A four-bit polarity word selects the active level of each output independently. A run input starts and stops the raster. Two one-cycle strobes support the surrounding logic. One marks the first pixel of each frame, which is the first pixel of vertical sync, and is meant for scanout logic. The other marks the first pixel after the last active line, and serves as a vertical blanking interrupt. The pixel source drives `pix_in` combinationally against the current clock cycle.

Top module: `vtg_top`

## Requirements
- R1: Each line is made of horizontal sync, back porch, active and front porch, in that order, lasting `h_sync_m1+1`, `h_back_m1+1`, `h_act_m1+1` and `h_front_m1+1` pixel clocks. `hsync` is active only during the sync region.
- R2: Each frame is made of vertical sync, back porch, active and front porch, in that order, lasting `v_*_m1+1` lines. A line ends when its front porch ends. `vsync` is active only during vertical sync lines.
- R3: `de` is active only when the horizontal and vertical positions are both in their active regions.
- R4: `polarity` bit 0 sets the level of `hsync`, bit 1 of `vsync`, bit 2 of `de` and bit 3 of `pix_out`. A bit of 1 means active high. A bit of 0 means active low.
- R5: While `de` is active, `pix_out` equals `pix_in`, or its bitwise inverse when polarity bit 3 is 0. Outside `de`, `pix_out` is all zeros when bit 3 is 1 and all ones when bit 3 is 0.
- R6: While `enable` is low, both positions are held at zero and every output sits at its inactive level. Suppose the clock edge that samples `enable` high follows a cycle in which the block was stopped. The cycle after that edge is the first pixel of horizontal and vertical sync, and each later edge advances one pixel.
- R7: `sof` is high for exactly one cycle, on the first pixel of vertical sync in every frame.
- R8: `vblank_irq` is high for exactly one cycle, on the first pixel of the first vertical front porch line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run (1) or stop (0) the raster |
| h_sync_m1 | input | H_W | Horizontal sync pixels minus one |
| h_back_m1 | input | H_W | Horizontal back porch pixels minus one |
| h_act_m1 | input | H_W | Horizontal active pixels minus one |
| h_front_m1 | input | H_W | Horizontal front porch pixels minus one |
| v_sync_m1 | input | V_W | Vertical sync lines minus one |
| v_back_m1 | input | V_W | Vertical back porch lines minus one |
| v_act_m1 | input | V_W | Vertical active lines minus one |
| v_front_m1 | input | V_W | Vertical front porch lines minus one |
| polarity | input | 4 | Active-high select: hsync, vsync, de, data |
| pix_in | input | DW | Pixel value for the current cycle |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | DW | Polarity-adjusted pixel data |
| sof | output | 1 | First-pixel-of-frame strobe |
| vblank_irq | output | 1 | Vertical blanking interrupt strobe |

## Verification
The outputs are combinational from the position registers, the running flag, the polarity word and the pixel input. The result of a clock edge is therefore visible from that edge until the next one. The driver sets the inputs at the falling edge and queues the expected output set for the cycle that follows the next rising edge. The monitor pops and compares that set two nanoseconds after the rising edge, so each result is checked in the one cycle it belongs to. A change of `enable` shows up one edge later and a change of polarity or pixel shows up at once, and the queued values follow both rules.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    localparam int POL_HS   = 0;
    localparam int POL_VS   = 1;
    localparam int POL_DE   = 2;
    localparam int POL_DATA = 3;
    localparam int POL_W    = 4;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic sof;
        logic irq;
    } raw_flags_t;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/vtg_axis_counter.sv
module vtg_axis_counter
    import vtg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               step,
    input  logic [3:0][W-1:0]  len,
    output phase_e             phase,
    output logic [W-1:0]       cnt,
    output logic               wrap,
    output logic               at_start
);

    logic last;

    assign last     = (cnt == len[phase]);
    assign wrap     = step && last && (phase == PH_FRONT);
    assign at_start = (phase == PH_SYNC) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (last) begin
                cnt   <= '0;
                phase <= phase_after(phase);
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: a stopped axis sits at zero after the next edge
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == PH_SYNC && cnt == '0));

    // R1 (and R2 for the vertical instance): regions only advance in order
    p_region_order_r1: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && phase != $past(phase)) |-> phase == phase_after($past(phase)));

endmodule

// File: rtl/vtg_out_stage.sv
module vtg_out_stage
    import vtg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             running,
    input  raw_flags_t       flags,
    input  logic [POL_W-1:0] pol,
    input  logic [DW-1:0]    pix_in,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [DW-1:0]    pix_out,
    output logic             sof,
    output logic             irq
);

    raw_flags_t act;
    logic [DW-1:0] pix_gated;

    always_comb begin
        act       = running ? flags : '0;
        hsync     = pol[POL_HS] ? act.hs : ~act.hs;
        vsync     = pol[POL_VS] ? act.vs : ~act.vs;
        de        = pol[POL_DE] ? act.de : ~act.de;
        pix_gated = act.de ? pix_in : '0;
        pix_out   = pix_gated ^ {DW{~pol[POL_DATA]}};
        sof       = act.sof;
        irq       = act.irq;
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 11,
    parameter int DW  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [H_W-1:0]   h_sync_m1,
    input  logic [H_W-1:0]   h_back_m1,
    input  logic [H_W-1:0]   h_act_m1,
    input  logic [H_W-1:0]   h_front_m1,
    input  logic [V_W-1:0]   v_sync_m1,
    input  logic [V_W-1:0]   v_back_m1,
    input  logic [V_W-1:0]   v_act_m1,
    input  logic [V_W-1:0]   v_front_m1,
    input  logic [POL_W-1:0] polarity,
    input  logic [DW-1:0]    pix_in,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [DW-1:0]    pix_out,
    output logic             sof,
    output logic             vblank_irq
);

    logic running;
    logic [3:0][H_W-1:0] h_len;
    logic [3:0][V_W-1:0] v_len;
    phase_e h_phase, v_phase;
    logic [H_W-1:0] h_cnt;
    logic [V_W-1:0] v_cnt;
    logic h_wrap, h_start, v_wrap, v_start;
    raw_flags_t flags;

    assign h_len = {h_front_m1, h_act_m1, h_back_m1, h_sync_m1};
    assign v_len = {v_front_m1, v_act_m1, v_back_m1, v_sync_m1};

    always_ff @(posedge clk) begin
        if (rst) running <= 1'b0;
        else     running <= enable;
    end

    vtg_axis_counter #(.W(H_W)) u_hcnt (
        .clk(clk), .rst(rst), .run(running), .step(1'b1), .len(h_len),
        .phase(h_phase), .cnt(h_cnt), .wrap(h_wrap), .at_start(h_start)
    );

    vtg_axis_counter #(.W(V_W)) u_vcnt (
        .clk(clk), .rst(rst), .run(running), .step(h_wrap), .len(v_len),
        .phase(v_phase), .cnt(v_cnt), .wrap(v_wrap), .at_start(v_start)
    );

    always_comb begin
        flags.hs  = (h_phase == PH_SYNC);
        flags.vs  = (v_phase == PH_SYNC);
        flags.de  = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        flags.sof = h_start && v_start;
        flags.irq = h_start && (v_phase == PH_FRONT) && (v_cnt == '0);
    end

    vtg_out_stage #(.DW(DW)) u_out (
        .running(running), .flags(flags), .pol(polarity), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
        .sof(sof), .irq(vblank_irq)
    );

    p_sof_single_r7: assert property (@(posedge clk) disable iff (rst)
        sof |=> !sof);

    p_sof_in_vsync_r7: assert property (@(posedge clk) disable iff (rst)
        sof |-> (vsync == polarity[POL_VS]));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> !vblank_irq);

    p_de_outside_sync_r3: assert property (@(posedge clk) disable iff (rst)
        (de == polarity[POL_DE]) |-> (hsync != polarity[POL_HS] && vsync != polarity[POL_VS]));

    p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (hsync != polarity[POL_HS] && vsync != polarity[POL_VS]
                     && de != polarity[POL_DE] && !sof && !vblank_irq));

    // v_wrap and v_start are kept for the frame-level checks here
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (running && enable && v_wrap) |=> v_start);

endmodule

// File: tb/tb_vtg_top.sv
module tb_vtg_top;

    localparam int H_W = 12;
    localparam int V_W = 11;
    localparam int DW  = 8;

    logic clk = 1'b0;
    logic rst, enable;
    logic [H_W-1:0] h_sync_m1, h_back_m1, h_act_m1, h_front_m1;
    logic [V_W-1:0] v_sync_m1, v_back_m1, v_act_m1, v_front_m1;
    logic [3:0] polarity;
    logic [DW-1:0] pix_in;
    logic hsync, vsync, de, sof, vblank_irq;
    logic [DW-1:0] pix_out;

    always #5 clk = ~clk;

    vtg_top #(.H_W(H_W), .V_W(V_W), .DW(DW)) dut (
        .clk(clk), .rst(rst), .enable(enable),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
        .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
        .polarity(polarity), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out),
        .sof(sof), .vblank_irq(vblank_irq)
    );

    typedef struct {
        logic hs;
        logic vs;
        logic de;
        logic [DW-1:0] pix;
        logic sof;
        logic irq;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state, derived from the requirements
    int hs_l, hb_l, ha_l, hf_l, vs_l, vb_l, va_l, vf_l;
    int hp = 0, vp = 0;
    bit run_m = 0;
    int cyc = 0;

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at t=%0t: actual %0h expected %0h", req, what, $time, act, exp);
        end
    endtask

    task automatic set_cfg(input int a, input int b, input int c, input int d,
                           input int e, input int f, input int g, input int h);
        hs_l = a; hb_l = b; ha_l = c; hf_l = d;
        vs_l = e; vb_l = f; va_l = g; vf_l = h;
        h_sync_m1 = H_W'(a - 1); h_back_m1 = H_W'(b - 1);
        h_act_m1  = H_W'(c - 1); h_front_m1 = H_W'(d - 1);
        v_sync_m1 = V_W'(e - 1); v_back_m1 = V_W'(f - 1);
        v_act_m1  = V_W'(g - 1); v_front_m1 = V_W'(h - 1);
    endtask

    // drive one cycle at the falling edge and queue the expectation for the next rising edge
    task automatic drive(input bit r, input bit en);
        exp_t e;
        bit hsr, vsr, der;
        rst = r;
        enable = en;
        pix_in = DW'(cyc * 37 + 5);
        cyc++;
        if (r || !run_m) begin
            hp = 0; vp = 0;
        end else begin
            hp++;
            if (hp == hs_l + hb_l + ha_l + hf_l) begin
                hp = 0;
                vp++;
                if (vp == vs_l + vb_l + va_l + vf_l) vp = 0;
            end
        end
        run_m = en && !r;
        hsr = run_m && (hp < hs_l);
        vsr = run_m && (vp < vs_l);
        der = run_m && (hp >= hs_l + hb_l) && (hp < hs_l + hb_l + ha_l)
                    && (vp >= vs_l + vb_l) && (vp < vs_l + vb_l + va_l);
        e.hs  = polarity[0] ? hsr : !hsr;
        e.vs  = polarity[1] ? vsr : !vsr;
        e.de  = polarity[2] ? der : !der;
        e.pix = (der ? pix_in : '0) ^ {DW{~polarity[3]}};
        e.sof = run_m && hp == 0 && vp == 0;
        e.irq = run_m && hp == 0 && vp == vs_l + vb_l + va_l;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic run_cycles(input int n, input bit en);
        for (int i = 0; i < n; i++) drive(1'b0, en);
    endtask

    // monitor: pops and compares two nanoseconds after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk("R1/R4", "hsync", DW'(hsync), DW'(e.hs));
                chk("R2/R4", "vsync", DW'(vsync), DW'(e.vs));
                chk("R3/R6", "de", DW'(de), DW'(e.de));
                chk("R5", "pix_out", pix_out, e.pix);
                chk("R7", "sof", DW'(sof), DW'(e.sof));
                chk("R8", "vblank_irq", DW'(vblank_irq), DW'(e.irq));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        polarity = 4'b1111;
        set_cfg(2, 3, 4, 2, 1, 2, 3, 1);
        // R6: reset state, outputs inactive
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b0);
        run_cycles(4, 1'b0);
        // R1 R2 R3 R7 R8: two frames plus, all active high
        run_cycles(170, 1'b1);
        // R6: stop, then change settings only while stopped
        run_cycles(5, 1'b0);
        polarity = 4'b0000;
        // R1: minimum one-pixel regions; R4 R5: all active low
        set_cfg(1, 1, 1, 1, 1, 1, 2, 1);
        run_cycles(2, 1'b0);
        run_cycles(50, 1'b1);
        // R6: stop in mid-frame and restart from the first sync pixel
        run_cycles(3, 1'b0);
        polarity = 4'b0101;
        run_cycles(2, 1'b0);
        run_cycles(60, 1'b1);
        // R4: mixed polarity with wider regions
        run_cycles(3, 1'b0);
        polarity = 4'b1010;
        set_cfg(3, 1, 5, 2, 2, 1, 2, 2);
        run_cycles(2, 1'b0);
        run_cycles(200, 1'b1);
        run_cycles(3, 1'b0);
        @(posedge clk);
        #3;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule